// File: doc/BRIEF.md
# PRBS31 Bit-Error-Rate Tester with Error Injection

This block runs a bit-error-rate test over a loopback path, one bit per transfer. A PRBS31 generator drives a transmit bit stream, and a checker on the receive stream seeds itself from the incoming data. Once the checker has seen a run of clean bits it locks and runs freely, so that a single corrupted bit is counted as one error. The error counter is 32 bits wide and saturating. It is read back through a 16-bit window in three slices.

Control arrives as already-decoded strobes. A command strobe carries an 8-bit code that starts the test, stops it, or fires the injector. A separate strobe arms error counting for the next run. Another strobe loads an injection amount. When the inject command is given during a run, the generator inverts that many transmitted bits, with the corrupted bits spaced apart. A 2-bit status shows whether the test is idle, running or complete.

Both bit streams use valid/ready. The transmit stream is valid only while a test runs, and it advances only on a cycle where valid and ready are both high. While ready is low, the offered bit is held unchanged. The receive side never applies back-pressure: its ready output is tied high, and a bit is taken on every cycle with rx_valid high.

Top module: `prbs_ber_tester`

## Requirements
- R1: While running, the transmitted bits obey b[n] = b[n-31] XOR b[n-28] (polynomial x^31 + x^28 + 1), reseeded to a nonzero state on every start; bits not deliberately corrupted never break this recurrence.
- R2: A transmit bit is transferred only when tx_valid and tx_ready are both high; while tx_valid is high and tx_ready low, tx_bit holds its value and the sequence does not advance.
- R3: Status encoding: 0 = idle (after reset), 1 = running, 3 = complete; 2 never appears. A stop given while not running is ignored.
- R4: With cmd_valid high, cmd_op 0x20 starts the test from any state, 0x21 stops a running test, and 0x23 fires the injector during a run; any other code has no effect.
- R5: A pulse on inj_load stores inj_amount (16 bits). The inject command then makes the generator invert exactly that many transmitted bits, with consecutive corrupted bits at least 64 transfers apart; an amount of 0 corrupts nothing.
- R6: Each corrupted bit that reaches the locked checker adds exactly one to the error count, and the checker stays locked.
- R7: The checker counts no error until it has filled its 31-bit history and then seen 31 consecutive bits that match the recurrence; a stream that never satisfies the recurrence leaves the count at zero.
- R8: Counting takes place only in a run started after an arm_count pulse; each start consumes the arming, so a run started without a fresh arm keeps a count of zero.
- R9: The error count saturates at all ones (2^CNT_W - 1) and does not wrap.
- R10: Start clears the count, including a restart from the complete state; after a stop the count is frozen whatever arrives on the receive stream.
- R11: rd_sel selects the readout: 0 gives count[11:0] zero-extended, 1 gives count[27:12], 2 gives count[31:28] zero-extended, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command code: 0x20 start, 0x21 stop, 0x23 inject |
| arm_count | input | 1 | Arms error counting for the next start |
| inj_load | input | 1 | Stores inj_amount |
| inj_amount | input | 16 | Number of bits to corrupt |
| tx_valid | output | 1 | Transmit bit valid (test running) |
| tx_ready | input | 1 | Transmit sink ready |
| tx_bit | output | 1 | Transmit bit |
| rx_valid | input | 1 | Receive bit valid |
| rx_ready | output | 1 | Always high |
| rx_bit | input | 1 | Receive bit |
| rd_sel | input | 2 | Count slice select |
| rd_data | output | 16 | Selected count slice |
| status | output | 2 | Test status |

## Verification
Saturation is the hardest case to reach from the ports. At one error per bit, filling a 32-bit count would take billions of cycles. The bench therefore builds a second instance with a 14-bit counter and feeds both instances the same received stream. Once both checkers are locked, the bench inverts every received bit for 20000 transfers. Each locked checker runs freely, so every one of those bits is an error. This gives an exact count on the wide instance, which exercises all three slices, and drives the narrow instance into saturation. The bench sweeps small injection amounts, and the value 0x123, with and without back-pressure on the transmit stream. It recovers each injected bit at the transmit port by checking the recurrence.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;
  localparam int LFSR_W = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd3
  } ber_state_t;

  localparam logic [7:0] OP_START  = 8'h20;
  localparam logic [7:0] OP_STOP   = 8'h21;
  localparam logic [7:0] OP_INJECT = 8'h23;

  // next bit of x^31 + x^28 + 1; s[0] holds the newest bit
  function automatic logic prbs31_next(input logic [LFSR_W-1:0] s);
    return s[30] ^ s[27];
  endfunction
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_ber_pkg::*;
#(
  parameter int INJ_W = 16,
  parameter int GAP   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reseed,
  input  logic             run,
  input  logic             adv,
  input  logic             trig,
  input  logic [INJ_W-1:0] trig_amount,
  output logic             bit_o,
  output logic             flip_o
);
  localparam int GAP_W = $clog2(GAP);
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(GAP - 1);

  logic [LFSR_W-1:0] lfsr;
  logic [INJ_W-1:0]  pending;
  logic [GAP_W-1:0]  gap;
  logic              fb;

  assign fb     = prbs31_next(lfsr);
  assign flip_o = run && (pending != '0) && (gap == '0);
  assign bit_o  = fb ^ flip_o;

  always_ff @(posedge clk) begin
    if (!rst_n || reseed) begin
      lfsr    <= '1;
      pending <= '0;
      gap     <= '0;
    end else begin
      if (adv) begin
        lfsr <= {lfsr[LFSR_W-2:0], fb};
        if (flip_o) gap <= GAP_RELOAD;
        else if (gap != '0) gap <= gap - 1'b1;
      end
      if (trig) pending <= trig_amount;
      else if (adv && flip_o) pending <= pending - 1'b1;
    end
  end
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_ber_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic rx_take,
  input  logic rx_bit,
  output logic locked,
  output logic err
);
  localparam logic [4:0] RUN_LEN = 5'(LFSR_W);

  logic [LFSR_W-1:0] hist;
  logic [4:0]        fill;
  logic [4:0]        good;
  logic              pred;
  logic              mism;

  assign pred = prbs31_next(hist);
  assign mism = rx_bit != pred;
  assign err  = rx_take && locked && mism;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist   <= '0;
      fill   <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else if (rx_take) begin
      // once locked, run on the own prediction so an error is not echoed
      hist <= {hist[LFSR_W-2:0], locked ? pred : rx_bit};
      if (fill != RUN_LEN) begin
        fill <= fill + 1'b1;
      end else if (!locked) begin
        if (mism) begin
          good <= '0;
        end else if (good == RUN_LEN - 1'b1) begin
          good   <= RUN_LEN;
          locked <= 1'b1;
        end else begin
          good <= good + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ber_ctrl.sv
module ber_ctrl
  import prbs_ber_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic             arm,
  input  logic             err,
  output ber_state_t       state,
  output logic             start_p,
  output logic             inj_p,
  output logic             cnt_inc,
  output logic [CNT_W-1:0] cnt
);
  logic armed;
  logic cnt_en;
  logic stop_p;

  assign start_p = cmd_valid && (cmd_op == OP_START);
  assign stop_p  = cmd_valid && (cmd_op == OP_STOP) && (state == ST_RUN);
  assign inj_p   = cmd_valid && (cmd_op == OP_INJECT) && (state == ST_RUN);
  assign cnt_inc = (state == ST_RUN) && cnt_en && err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      armed  <= 1'b0;
      cnt_en <= 1'b0;
      cnt    <= '0;
    end else begin
      if (arm) armed <= 1'b1;
      if (start_p) begin
        state  <= ST_RUN;
        cnt    <= '0;
        cnt_en <= armed;
        armed  <= 1'b0;
      end else if (stop_p) begin
        state <= ST_DONE;
      end else if (cnt_inc && (cnt != '1)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prbs_ber_tester.sv
module prbs_ber_tester
  import prbs_ber_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INJ_W = 16,
  parameter int GAP   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic        arm_count,
  input  logic        inj_load,
  input  logic [15:0] inj_amount,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_bit,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic        rx_bit,
  input  logic [1:0]  rd_sel,
  output logic [15:0] rd_data,
  output logic [1:0]  status
);
  ber_state_t       state;
  logic             start_p;
  logic             inj_p;
  logic             cnt_inc;
  logic [CNT_W-1:0] err_cnt;
  logic [INJ_W-1:0] inj_reg;
  logic             adv;
  logic             flip;
  logic             locked;
  logic             err;
  logic [31:0]      cnt_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) inj_reg <= '0;
    else if (inj_load) inj_reg <= INJ_W'(inj_amount);
  end

  assign tx_valid = (state == ST_RUN);
  assign adv      = tx_valid && tx_ready;
  assign rx_ready = 1'b1;
  assign status   = state;

  ber_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .arm(arm_count), .err(err), .state(state), .start_p(start_p),
    .inj_p(inj_p), .cnt_inc(cnt_inc), .cnt(err_cnt)
  );

  prbs_gen #(.INJ_W(INJ_W), .GAP(GAP)) u_gen (
    .clk(clk), .rst_n(rst_n), .reseed(start_p), .run(tx_valid), .adv(adv),
    .trig(inj_p), .trig_amount(inj_reg), .bit_o(tx_bit), .flip_o(flip)
  );

  prbs_chk u_chk_rx (
    .clk(clk), .rst_n(rst_n), .clear(start_p), .rx_take(rx_valid && rx_ready),
    .rx_bit(rx_bit), .locked(locked), .err(err)
  );

  assign cnt_ext = 32'(err_cnt);

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {4'h0, cnt_ext[11:0]};
      2'd1:    rd_data = cnt_ext[27:12];
      2'd2:    rd_data = {12'h000, cnt_ext[31:28]};
      default: rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/prbs_ber_tester_chk.sv
module prbs_ber_tester_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             start_p,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_bit,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] err_cnt,
  input logic             cnt_inc,
  input logic             locked,
  input logic             flip,
  input logic             adv
);
  logic [6:0] since_flip;

  always_ff @(posedge clk) begin
    if (!rst_n || start_p) since_flip <= 7'd127;
    else if (adv) begin
      if (flip) since_flip <= '0;
      else if (since_flip != 7'd127) since_flip <= since_flip + 1'b1;
    end
  end

  // R2
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cmd_valid) |=> $stable(tx_bit));

  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd2);

  // R5
  inj_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && adv) |-> (since_flip >= 7'd63));

  // R7
  count_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> locked);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_cnt == '1) && !start_p) |=> (err_cnt == '1));

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (err_cnt == '0));

  // R10
  frozen_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 2'd3) && !start_p) |=> $stable(err_cnt));
endmodule

bind prbs_ber_tester prbs_ber_tester_chk #(.CNT_W(CNT_W)) u_assert (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .start_p(start_p),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit), .status(status),
  .err_cnt(err_cnt), .cnt_inc(cnt_inc), .locked(locked), .flip(flip), .adv(adv)
);

// File: tb/prbs_ber_tester_test.sv
module prbs_ber_tester_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic        arm_count = 1'b0;
  logic        inj_load = 1'b0;
  logic [15:0] inj_amount = 16'h0;
  logic        tx_ready;
  logic [1:0]  rd_sel = 2'd0;
  logic        tx_valid, tx_bit, rx_ready, s_tx_valid, s_tx_bit, s_rx_ready;
  logic [15:0] rd_data, s_rd_data;
  logic [1:0]  status, s_status;
  logic        rx_valid, rx_bit;
  logic [LAT-1:0] dly_v = '0, dly_b = '0;
  logic        inv = 1'b0, force_rx = 1'b0, force_val = 1'b0;
  logic        bp = 1'b0;
  int unsigned cyc = 0;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  // bench view of transmitted stream
  logic [30:0] hist = '0;
  int          nbits = 0, viol = 0, min_gap = 1000000, last_viol = -1000000;

  always #10 clk = ~clk;

  assign tx_ready = bp ? ((cyc % 3) != 0) : 1'b1;
  assign rx_valid = force_rx ? 1'b1 : dly_v[LAT-1];
  assign rx_bit   = force_rx ? force_val : (dly_b[LAT-1] ^ inv);

  prbs_ber_tester uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .arm_count(arm_count), .inj_load(inj_load), .inj_amount(inj_amount),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .rd_sel(rd_sel), .rd_data(rd_data), .status(status)
  );

  prbs_ber_tester #(.CNT_W(14)) uut_sat (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .arm_count(arm_count), .inj_load(inj_load), .inj_amount(inj_amount),
    .tx_valid(s_tx_valid), .tx_ready(tx_ready), .tx_bit(s_tx_bit),
    .rx_valid(rx_valid), .rx_ready(s_rx_ready), .rx_bit(rx_bit),
    .rd_sel(rd_sel), .rd_data(s_rd_data), .status(s_status)
  );

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    dly_v <= {dly_v[LAT-2:0], tx_valid && tx_ready};
    dly_b <= {dly_b[LAT-2:0], tx_bit};
    if (cmd_valid && cmd_op == 8'h20) begin
      nbits <= 0; viol <= 0; min_gap <= 1000000; last_viol <= -1000000;
    end else if (tx_valid && tx_ready) begin
      if (nbits >= 31 && tx_bit != (hist[30] ^ hist[27])) begin
        viol <= viol + 1;
        if (nbits - last_viol < min_gap) min_gap <= nbits - last_viol;
        last_viol <= nbits;
        hist <= {hist[29:0], hist[30] ^ hist[27]};
      end else begin
        hist <= {hist[29:0], tx_bit};
      end
      nbits <= nbits + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 8'h00;
  endtask

  task automatic arm();
    @(negedge clk); arm_count = 1'b1;
    @(negedge clk); arm_count = 1'b0;
  endtask

  task automatic load(input int n);
    @(negedge clk); inj_load = 1'b1; inj_amount = 16'(n);
    @(negedge clk); inj_load = 1'b0;
  endtask

  task automatic read_count(input string req, input int exp, input int s_exp);
    for (int s = 0; s < 4; s++) begin
      int e, se;
      @(negedge clk); rd_sel = 2'(s); #1;
      case (s)
        0: begin e = exp & 32'hFFF; se = s_exp & 32'hFFF; end
        1: begin e = (exp >> 12) & 32'hFFFF; se = (s_exp >> 12) & 32'hFFFF; end
        2: begin e = (exp >> 28) & 32'hF; se = (s_exp >> 28) & 32'hF; end
        default: begin e = 0; se = 0; end
      endcase
      chk(rd_data == 16'(e), {req, " R11 slice"}, int'(rd_data), e);
      if (s_exp >= 0) chk(s_rd_data == 16'(se), {req, " R9 narrow slice"}, int'(s_rd_data), se);
    end
  endtask

  task automatic inj_run(input int n, input bit armed, input bit use_bp);
    bp = use_bp;
    if (armed) arm();
    cmd(8'h20);
    tick(300);
    chk(status == 2'd1, "R3 running", int'(status), 1);
    load(n);
    cmd(8'h23);
    tick(n * 64 * 3 + 300);
    cmd(8'h21);
    tick(2); #1;
    chk(status == 2'd3, "R3 complete", int'(status), 3);
    chk(viol == n, "R5 corrupted bit count", viol, n);
    if (n > 1) chk(min_gap >= 64, "R5 spacing", min_gap, 64);
    // R6 one error per corrupted bit; R8 nothing counted when not armed
    read_count(armed ? "R6" : "R8", armed ? n : 0, -1);
    bp = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1); #1;
    chk(status == 2'd0, "R3 reset idle", int'(status), 0);
    chk(tx_valid == 1'b0, "R2 no valid when idle", int'(tx_valid), 0);
    chk(rx_ready == 1'b1, "R2 rx always ready", int'(rx_ready), 1);
    read_count("R10 reset", 0, 0);
    cmd(8'h21);
    #1 chk(status == 2'd0, "R3 stop ignored when idle", int'(status), 0);
    cmd(8'h22);
    #1 chk(status == 2'd0, "R4 unknown code", int'(status), 0);

    // R1 recurrence with back-pressure and no injection
    bp = 1'b1;
    arm(); cmd(8'h20);
    tick(2000);
    cmd(8'h22);
    #1 chk(status == 2'd1, "R4 unknown code in run", int'(status), 1);
    chk(nbits > 1000, "R2 stream advances", nbits, 1000);
    chk(viol == 0, "R1 recurrence", viol, 0);
    cmd(8'h21); tick(3);
    read_count("R1 clean run", 0, 0);
    bp = 1'b0;

    // R5/R6/R8 sweep
    for (int n = 0; n <= 8; n++) inj_run(n, 1'b1, n[0]);
    inj_run(3, 1'b0, 1'b0);
    inj_run(16'h123, 1'b1, 1'b1);

    // R7 no lock on a stream that breaks the recurrence
    arm(); cmd(8'h20);
    @(negedge clk); force_rx = 1'b1; force_val = 1'b1;
    tick(400);
    force_rx = 1'b0;
    tick(300);
    cmd(8'h21); tick(2);
    read_count("R7", 0, 0);

    // R9 saturation / R11 slices: every locked bit inverted
    arm(); cmd(8'h20);
    tick(300);
    inv = 1'b1;
    tick(20000);
    inv = 1'b0;
    tick(20);
    cmd(8'h21); tick(2);
    read_count("R9", 20000, 16383);

    // R10 frozen after stop
    @(negedge clk); force_rx = 1'b1;
    for (int i = 0; i < 200; i++) begin
      force_val = i[1] ^ i[0];
      @(negedge clk);
    end
    force_rx = 1'b0;
    read_count("R10 frozen", 20000, 16383);

    // R10 restart from complete clears the count
    cmd(8'h20);
    #1 chk(status == 2'd1, "R10 restart status", int'(status), 1);
    read_count("R10 restart", 0, 0);
    cmd(8'h21);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule